// File: doc/BRIEF.md
# Waveform Playback Sample Repeater

This block plays one generator channel out of a local sample buffer into a 14-bit DAC. The DAC is clocked at a fixed 100 MS/s and takes a new code on every cycle. A slower output rate of 10^8/N samples per second comes from holding each buffer sample for N consecutive clock cycles, not from changing the clock. The block also sets the length of the waveform before it loops, so one period of the output is `play_len` samples long.

Each signed sample goes through a fine digital amplitude multiplier in unsigned Q1.15 format. The product is rounded and clamped. The result is then turned into the DAC's code. That code is inverted offset binary: code 0 drives the output to positive full scale and codes near 16383 drive it to negative full scale. A separate registered bit picks the coarse analog gain. The two settings differ by 4:1 in full-scale current.

The buffer read is combinational: the block presents `buf_addr` and expects the sample at that address on `buf_data` in the same cycle. While the block is disabled it parks the DAC at the code for zero volts.

Top module: `awg_sample_repeater`

## Requirements
- R1: While `rst_n` is low, `dac_code` is 8192, `buf_addr` is 0 and `gain_sel` is 0.
- R2: While `enable` is low, `dac_code` is 8192 after every clock edge and `buf_addr` is 0, whatever is on `buf_data`.
- R3: At the first rising clock edge that sees `enable` high, `dac_code` takes the converted value of the sample at buffer address 0.
- R4: Each buffer sample appears on `dac_code` for exactly `repeat_n` consecutive cycles before the next address is used. A `repeat_n` of 0 behaves like 1.
- R5: The read address counts up by one per sample and returns to 0 after address `play_len`−1. A `play_len` of 0 or 1 keeps the address at 0.
- R6: The scaled value is y = floor((s·k + 2^14) / 2^15), where s is the signed 14-bit sample and k is the unsigned 16-bit `amp_scale`. A k of 0x8000 is unity gain.
- R7: y is clamped to the range −8192..8191 before code conversion.
- R8: `dac_code` = 8192 − y, capped at 16383. So y = 0 gives 8192, y = 8191 gives 1 and y = −8192 gives 16383.
- R9: `gain_sel` equals the value `gain_hi` had at the previous clock edge. A value of 1 selects the high-gain (4× full scale) analog range.
- R10: Dropping `enable` for one cycle puts 8192 on `dac_code` at the next edge. The next enable starts playback again from address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 100 MHz DAC update clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Playback enable |
| gain_hi | input | 1 | Requested coarse gain (1 = high) |
| play_len | input | $clog2(DEPTH)+1 | Number of samples in one waveform period |
| repeat_n | input | REP_W | Cycles each sample is held |
| amp_scale | input | 16 | Fine amplitude factor, unsigned Q1.15 |
| buf_addr | output | $clog2(DEPTH) | Sample buffer read address |
| buf_data | input | 14 | Signed sample read from `buf_addr` |
| dac_code | output | 14 | Inverted offset-binary DAC code |
| gain_sel | output | 1 | Registered coarse gain select |

## Verification
The arithmetic is exercised with single-sample waveforms under several scale factors: unity, one half, one and a half, zero and the smallest non-zero factor. This separates the rounding direction for positive and negative halves, and it shows clamping at both ends of the scaled range as distinct from clamping in the code conversion. Sequencing is exercised with a four-sample ramp held three cycles per sample. That pattern exposes an off-by-one in the repeat counter, a late first sample and a wrong wrap point. Separate runs with a repeat count of 0 and a length of 0 confirm the degenerate settings. A disable in the middle of a sample shows that playback restarts from address 0 rather than resuming.

// File: rtl/awg_rep_pkg.sv
package awg_rep_pkg;
  localparam int SAMPLE_W = 14;
  localparam int SCALE_W  = 16;
  localparam int FRAC_W   = 15;
  localparam int CODE_W   = SAMPLE_W;
  localparam int PROD_W   = SAMPLE_W + SCALE_W + 2;

  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1 << (CODE_W - 1));

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic [CODE_W-1:0]          code_t;

  // Multiply by the Q1.15 factor, round half up, clamp to the sample range.
  function automatic sample_t scale_sample(input sample_t s, input logic [SCALE_W-1:0] k);
    logic signed [PROD_W-1:0] sx;
    logic signed [PROD_W-1:0] kx;
    logic signed [PROD_W-1:0] rnd;
    sx  = PROD_W'(s);
    kx  = $signed({{(PROD_W-SCALE_W){1'b0}}, k});
    rnd = (sx * kx + $signed(PROD_W'(1 << (FRAC_W - 1)))) >>> FRAC_W;
    if (rnd > $signed(PROD_W'((1 << (SAMPLE_W - 1)) - 1)))
      return sample_t'((1 << (SAMPLE_W - 1)) - 1);
    else if (rnd < -$signed(PROD_W'(1 << (SAMPLE_W - 1))))
      return sample_t'(-(1 << (SAMPLE_W - 1)));
    else
      return $signed(rnd[SAMPLE_W-1:0]);
  endfunction

  // Inverted offset binary: midscale minus the sample, capped at the top code.
  function automatic code_t to_code(input sample_t y);
    logic signed [CODE_W+1:0] d;
    d = $signed({2'b00, MID_CODE}) - (CODE_W+2)'(y);
    if (d > $signed((CODE_W+2)'((1 << CODE_W) - 1)))
      return code_t'((1 << CODE_W) - 1);
    else
      return d[CODE_W-1:0];
  endfunction
endpackage

// File: rtl/rep_addr_gen.sv
module rep_addr_gen #(
  parameter int ADDR_W = 12,
  parameter int REP_W  = 16,
  localparam int LEN_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [LEN_W-1:0]  len,
  input  logic [REP_W-1:0]  rep_n,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              step,
  output logic              wrap
);
  logic [REP_W-1:0] rep_cnt;
  logic [REP_W:0]   rep_next;
  logic [LEN_W-1:0] addr_next;

  assign rep_next  = {1'b0, rep_cnt} + 1'b1;
  assign addr_next = {1'b0, rd_addr} + 1'b1;
  // A repeat count or length of zero falls through the >= test as one.
  assign step = en && (rep_next >= {1'b0, rep_n});
  assign wrap = step && (addr_next >= len);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      rep_cnt <= '0;
      rd_addr <= '0;
    end else if (step) begin
      rep_cnt <= '0;
      rd_addr <= wrap ? '0 : addr_next[ADDR_W-1:0];
    end else begin
      rep_cnt <= rep_next[REP_W-1:0];
    end
  end

  p_idle_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> rd_addr == '0);
  p_hold_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step) |=> $stable(rd_addr));
  p_addr_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wrap) |=> rd_addr == $past(rd_addr) + 1'b1);
  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> rd_addr == '0);
endmodule

// File: rtl/rep_sample_path.sv
module rep_sample_path
  import awg_rep_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  sample_t            sample,
  input  logic [SCALE_W-1:0] scale,
  output code_t              code
);
  sample_t scaled;
  code_t   code_nxt;

  assign scaled   = scale_sample(sample, scale);
  assign code_nxt = to_code(scaled);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) code <= MID_CODE;
    else               code <= code_nxt;
  end

  p_idle_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> code == MID_CODE);
  p_code_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> code != '0);
endmodule

// File: rtl/awg_sample_repeater.sv
module awg_sample_repeater
  import awg_rep_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int REP_W = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = ADDR_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic                       gain_hi,
  input  logic [LEN_W-1:0]           play_len,
  input  logic [REP_W-1:0]           repeat_n,
  input  logic [15:0]                amp_scale,
  output logic [ADDR_W-1:0]          buf_addr,
  input  logic signed [SAMPLE_W-1:0] buf_data,
  output logic [CODE_W-1:0]          dac_code,
  output logic                       gain_sel
);
  logic addr_step;
  logic addr_wrap;

  rep_addr_gen #(.ADDR_W(ADDR_W), .REP_W(REP_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .en(enable), .len(play_len), .rep_n(repeat_n),
    .rd_addr(buf_addr), .step(addr_step), .wrap(addr_wrap)
  );

  rep_sample_path u_path (
    .clk(clk), .rst_n(rst_n), .en(enable), .sample(buf_data),
    .scale(amp_scale), .code(dac_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) gain_sel <= 1'b0;
    else        gain_sel <= gain_hi;
  end

  p_wrap_needs_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wrap |-> addr_step);
  p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> buf_addr == '0);
endmodule

// File: tb/awg_sample_repeater_tb_top.sv
module awg_sample_repeater_tb_top;
  localparam int DEPTH = 4096;
  localparam int LW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic gain_hi = 1'b0;
  logic [LW-1:0] play_len = '0;
  logic [15:0] repeat_n = '0;
  logic [15:0] amp_scale = 16'h8000;
  logic [LW-2:0] buf_addr;
  logic signed [13:0] buf_data;
  logic [13:0] dac_code;
  logic gain_sel;
  logic signed [13:0] mem [16];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign buf_data = mem[buf_addr[3:0]];

  awg_sample_repeater #(.DEPTH(DEPTH), .REP_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .gain_hi(gain_hi),
    .play_len(play_len), .repeat_n(repeat_n), .amp_scale(amp_scale),
    .buf_addr(buf_addr), .buf_data(buf_data), .dac_code(dac_code),
    .gain_sel(gain_sel)
  );

  typedef struct packed {
    logic signed [13:0] s;
    logic [15:0]        k;
    logic [13:0]        code;
  } vec_t;

  // Hand-computed: y = floor((s*k + 16384)/32768) clamped (R6, R7), code = 8192 - y capped (R8)
  localparam vec_t VECS [13] = '{
    '{14'sd1000,  16'h8000, 14'd7192},   // R6 unity
    '{-14'sd1000, 16'h8000, 14'd9192},   // R6 unity negative
    '{14'sd8191,  16'hFFFF, 14'd1},      // R7 clamp high
    '{-14'sd8192, 16'hFFFF, 14'd16383},  // R7 clamp low, R8 cap
    '{14'sd100,   16'h4000, 14'd8142},   // R6 half
    '{14'sd3,     16'h4000, 14'd8190},   // R6 +1.5 rounds to 2
    '{-14'sd3,    16'h4000, 14'd8193},   // R6 -1.5 rounds to -1
    '{14'sd5000,  16'h0000, 14'd8192},   // R6 zero scale
    '{-14'sd8192, 16'h8000, 14'd16383},  // R8 cap at top code
    '{14'sd8191,  16'h8000, 14'd1},      // R8 lowest code
    '{14'sd6000,  16'hC000, 14'd1},      // R7 1.5x overflow
    '{-14'sd6000, 16'hC000, 14'd16383},  // R7 1.5x underflow
    '{14'sd1,     16'h0001, 14'd8192}    // R6 tiny factor rounds to 0
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int unity_code(input logic signed [13:0] s);
    return 8192 - int'(s);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 14'(i * 100 + 100);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 dac_code", dac_code, 8192);
    check("R1 buf_addr", buf_addr, 0);
    check("R1 gain_sel", gain_sel, 0);
    rst_n = 1'b1;

    // R2 idle output ignores buffer content
    mem[0] = 14'sd1234;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R2 idle code", dac_code, 8192);
      check("R2 idle addr", buf_addr, 0);
    end

    // Table walk: arithmetic with a one-sample waveform
    for (int v = 0; v < 13; v++) begin
      enable = 1'b0;
      tick();
      mem[0] = VECS[v].s;
      amp_scale = VECS[v].k;
      play_len = LW'(1);
      repeat_n = 16'd1;
      enable = 1'b1;
      tick();
      check($sformatf("R6/R7/R8 vector %0d", v), dac_code, VECS[v].code);
    end

    // Ramp of 4 samples, each held 3 cycles
    enable = 1'b0;
    tick();
    for (int i = 0; i < 16; i++) mem[i] = 14'(i * 100 + 100);
    amp_scale = 16'h8000;
    play_len = LW'(4);
    repeat_n = 16'd3;
    enable = 1'b1;
    for (int k = 0; k < 15; k++) begin
      tick();
      if (k == 0)       check("R3 first sample", dac_code, unity_code(mem[0]));
      else if (k == 12) check("R5 wrap to 0", dac_code, unity_code(mem[0]));
      else              check("R4 repeat hold", dac_code, unity_code(mem[(k / 3) % 4]));
    end

    // R10 mid-sample disable then restart
    enable = 1'b0;
    tick();
    check("R10 disable code", dac_code, 8192);
    check("R10 disable addr", buf_addr, 0);
    enable = 1'b1;
    tick();
    check("R10 restart sample", dac_code, unity_code(mem[0]));

    // R4 repeat count of zero acts as one
    enable = 1'b0;
    tick();
    repeat_n = 16'd0;
    play_len = LW'(3);
    enable = 1'b1;
    for (int k = 0; k < 6; k++) begin
      tick();
      check("R4 repeat zero", dac_code, unity_code(mem[k % 3]));
    end

    // R5 length zero holds address 0
    enable = 1'b0;
    tick();
    repeat_n = 16'd1;
    play_len = '0;
    enable = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R5 len zero code", dac_code, unity_code(mem[0]));
      check("R5 len zero addr", buf_addr, 0);
    end

    // R9 gain select lags one edge
    gain_hi = 1'b1;
    #1;
    check("R9 before edge", gain_sel, 0);
    tick();
    check("R9 high", gain_sel, 1);
    gain_hi = 1'b0;
    tick();
    check("R9 low", gain_sel, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule